// File: doc/BRIEF.md
# Noise-Shaped Fractional Clock Divider

This block derives a slower clock from the source clock it runs on. The division ratio has an integer part N and a 12-bit fraction F, so the target ratio is N + F/4096. A control word enables the output, names the source that an external multiplexer should route to the block, and sets a noise-shaping order from 0 to 3.

At order 0 only N is applied and F has no effect, so the output runs fast. At order 1 a single phase accumulator lengthens some periods by one source cycle, so the long-run ratio is N + F/4096. Orders 2 and 3 cascade further accumulators. Their combined carries move each period over a wider span, which pushes the spread of period lengths to higher frequencies. Each order also sets a floor on N, so no period is ever shorter than two source cycles.

Software writes the two words through a plain write strobe. A write is accepted on every cycle it is presented, so there is no back-pressure. New settings take effect at the next period boundary.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is applied and after it is released, `clk_out` is low and `src_sel` is 0, and no pulse appears until the enable bit is written as 1.
- R2: A write with `cfg_sel`=0 loads the control word. In that word, bits 3:0 are the source select, driven on `src_sel` from the cycle after the write. Bit 4 is the enable. Bits 10:9 are the shaping order, and a nonzero order also enables the fraction. A write with `cfg_sel`=1 loads the divisor word, with N in bits 23:12 and F in bits 11:0; 0x00013333 gives N=19 and F=819. A divisor write also zeroes the accumulators.
- R3: At order 0 every period is exactly N source cycles, whatever the value of F.
- R4: At order 1 every period is N or N+1 cycles. Any 4096 consecutive periods total exactly 4096*N + F cycles, and any 256 consecutive periods total floor(256*F/4096) or one more above 256*N.
- R5: At order 2 every period lies in N-1..N+2. Any 4096 consecutive periods total within 1 cycle of 4096*N + F.
- R6: At order 3 every period lies in N-3..N+4. Any 4096 consecutive periods total within 3 cycles of 4096*N + F.
- R7: The effective N is raised to a floor of 2, 2, 3 or 5 for orders 0, 1, 2 and 3, and is left alone when it is already at or above that floor. With F=0 every period then equals the effective N.
- R8: Each period begins with a rising edge of `clk_out`. The output stays high for floor(P/2) cycles and is low for the rest of the period of length P.
- R9: Clearing the enable lets the current period run to its end and then holds `clk_out` low, with no shortened high pulse. Setting it again restarts with full periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock, the one being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the selected word |
| cfg_sel | input | 1 | 0 selects the control word, 1 the divisor word |
| cfg_wdata | input | 32 | Write data |
| src_sel | output | 4 | Source select for the external clock multiplexer |
| clk_out | output | 1 | Divided output clock |

## Verification
`src_sel` is due one cycle after the write edge. The bench samples it at the falling edge that follows the write. A new ratio or order only takes hold at a period boundary, after the period in progress and after the shaper history settles. For that reason the bench measures rising-edge to rising-edge intervals at falling edges, and discards a handful of warm-up periods after every reconfiguration before it checks any period length, high time or 4096-period total. For the disable case the bench counts high samples from the rising edge that precedes the write, so the expected high time is the full floor(P/2) regardless of where in the period the write lands.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  typedef enum logic [1:0] {
    ORD0 = 2'd0,
    ORD1 = 2'd1,
    ORD2 = 2'd2,
    ORD3 = 2'd3
  } mash_order_e;

  localparam int CTL_SRC_LSB  = 0;
  localparam int CTL_EN_BIT   = 4;
  localparam int CTL_ORD_LSB  = 9;

  // smallest integer divisor that keeps every period at two cycles or more
  function automatic int unsigned int_floor(mash_order_e ord);
    case (ord)
      ORD2:    return 3;
      ORD3:    return 5;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/frac_div_regs.sv
module frac_div_regs
  import frac_div_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 12,
  parameter int SRC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [SRC_W-1:0]  src_sel,
  output logic              run_en,
  output mash_order_e       order,
  output logic [INT_W-1:0]  n_int,
  output logic [FRAC_W-1:0] frac,
  output logic              div_wr
);

  localparam int DIV_MSB = FRAC_W + INT_W - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel <= '0;
      run_en  <= 1'b0;
      order   <= ORD0;
    end else if (cfg_wr && !cfg_sel) begin
      src_sel <= cfg_wdata[CTL_SRC_LSB +: SRC_W];
      run_en  <= cfg_wdata[CTL_EN_BIT];
      order   <= mash_order_e'(cfg_wdata[CTL_ORD_LSB +: 2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_int <= '0;
      frac  <= '0;
    end else if (cfg_wr && cfg_sel) begin
      n_int <= cfg_wdata[DIV_MSB:FRAC_W];
      frac  <= cfg_wdata[FRAC_W-1:0];
    end
  end

  assign div_wr = cfg_wr && cfg_sel;

  generate
    if (DIV_MSB < 31) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^cfg_wdata[31:DIV_MSB+1];
    end
  endgenerate

endmodule

// File: rtl/frac_div_noise.sv
module frac_div_noise
  import frac_div_pkg::*;
#(
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  mash_order_e       order,
  input  logic [FRAC_W-1:0] frac,
  output logic signed [3:0] delta
);

  localparam int STAGES = 3;
  localparam int HIST   = 3;

  logic [STAGES-1:0][FRAC_W:0]  sum;
  logic [STAGES-1:0][HIST-1:0]  cy_all;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [FRAC_W-1:0] addend;
      logic [FRAC_W-1:0] acc_q;
      logic [HIST-1:0]   cy_q;

      if (s == 0) begin : g_head
        assign addend = (order == ORD0) ? '0 : frac;
      end else begin : g_tail
        assign addend = sum[s-1][FRAC_W-1:0];
      end

      assign sum[s]    = {1'b0, acc_q} + {1'b0, addend};
      assign cy_all[s] = cy_q;

      // bit 0 holds the newest carry, higher bits hold older ones
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc_q <= '0;
          cy_q  <= '0;
        end else if (clr) begin
          acc_q <= '0;
          cy_q  <= '0;
        end else if (step) begin
          acc_q <= sum[s][FRAC_W-1:0];
          cy_q  <= {cy_q[HIST-2:0], sum[s][FRAC_W]};
        end
      end
    end
  endgenerate

  always_comb begin
    int d1;
    int d2;
    int d3;
    int tot;
    d1 = int'(cy_all[0][0]);
    d2 = int'(cy_all[1][0]) - int'(cy_all[1][1]);
    d3 = int'(cy_all[2][0]) - 2 * int'(cy_all[2][1]) + int'(cy_all[2][2]);
    case (order)
      ORD0:    tot = 0;
      ORD1:    tot = d1;
      ORD2:    tot = d1 + d2;
      default: tot = d1 + d2 + d3;
    endcase
    delta = 4'(tot);
  end

endmodule

// File: rtl/frac_div_period.sv
module frac_div_period
  import frac_div_pkg::*;
#(
  parameter int INT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  mash_order_e       order,
  input  logic [INT_W-1:0]  n_int,
  input  logic signed [3:0] delta,
  output logic              clk_out,
  output logic              load,
  output logic              running,
  output logic [INT_W+1:0]  plen
);

  localparam int PW = INT_W + 2;

  logic [INT_W-1:0] floor_v;
  logic [INT_W-1:0] n_eff;
  logic [PW-1:0]    p_next;
  logic [PW-1:0]    pos;
  logic [PW-1:0]    half;
  logic             last;

  assign floor_v = INT_W'(int_floor(order));
  assign n_eff   = (n_int < floor_v) ? floor_v : n_int;
  assign p_next  = PW'(n_eff) + {{(PW-4){delta[3]}}, delta};
  assign last    = (pos == plen - PW'(1));
  assign load    = run_en && (!running || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      clk_out <= 1'b0;
      pos     <= '0;
      plen    <= '0;
      half    <= '0;
    end else if (load) begin
      running <= 1'b1;
      clk_out <= 1'b1;
      pos     <= '0;
      plen    <= p_next;
      half    <= p_next >> 1;
    end else if (running) begin
      if (last) begin
        running <= 1'b0;
        clk_out <= 1'b0;
        pos     <= '0;
      end else begin
        pos     <= pos + PW'(1);
        clk_out <= (pos + PW'(1)) < half;
      end
    end
  end

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 12,
  parameter int SRC_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic [SRC_W-1:0] src_sel,
  output logic             clk_out
);

  logic              run_en;
  mash_order_e       order;
  logic [INT_W-1:0]  n_int;
  logic [FRAC_W-1:0] frac;
  logic              div_wr;
  logic signed [3:0] delta;
  logic              load;
  logic              running;
  logic [INT_W+1:0]  plen;
  logic              shaper_clr;

  assign shaper_clr = !running || div_wr;

  frac_div_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .SRC_W(SRC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .src_sel(src_sel), .run_en(run_en),
    .order(order), .n_int(n_int), .frac(frac), .div_wr(div_wr)
  );

  frac_div_noise #(.FRAC_W(FRAC_W)) u_noise (
    .clk(clk), .rst_n(rst_n), .clr(shaper_clr), .step(load),
    .order(order), .frac(frac), .delta(delta)
  );

  frac_div_period #(.INT_W(INT_W)) u_period (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .order(order),
    .n_int(n_int), .delta(delta), .clk_out(clk_out), .load(load),
    .running(running), .plen(plen)
  );

endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk
  import frac_div_pkg::*;
#(
  parameter int PW = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [3:0]        src_sel,
  input logic              clk_out,
  input logic              load,
  input logic              running,
  input logic [PW-1:0]     plen,
  input mash_order_e       order,
  input logic signed [3:0] delta
);

  assert_src_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr) |-> $stable(src_sel));

  assert_no_fraction_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (order == ORD0) |-> (delta == 4'sd0));

  assert_span_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (order == ORD1) |-> (delta == 4'sd0 || delta == 4'sd1));

  assert_span_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (order == ORD2) |-> (delta >= -4'sd1 && delta <= 4'sd2));

  assert_span_third_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (order == ORD3) |-> (delta >= -4'sd3 && delta <= 4'sd4));

  assert_period_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (plen >= PW'(2)));

  assert_rise_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> clk_out);

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !clk_out);

endmodule

bind frac_clk_div frac_clk_div_chk #(.PW(INT_W + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .src_sel(src_sel),
  .clk_out(clk_out), .load(load), .running(running), .plen(plen),
  .order(order), .delta(delta)
);

// File: tb/frac_clk_div_test.sv
`timescale 1ns/1ps
module frac_clk_div_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  src_sel;
  logic        clk_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  frac_clk_div uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .src_sel(src_sel), .clk_out(clk_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  function automatic logic [31:0] divw(input int n, input int f);
    return (32'(n) << 12) | 32'(f);
  endfunction

  // ctl word: source in 3:0, enable in bit 4, order in 10:9
  function automatic logic [31:0] ctlw(input int src, input int ord, input bit en);
    return 32'(src) | (32'(en) << 4) | (32'(ord) << 9);
  endfunction

  // measures nper whole periods after skipping warm rising edges
  task automatic measure(input int warm, input int nper, output longint total,
                         output int pmin, output int pmax, output int hibad);
    int edges = 0;
    int cyc = 0;
    int hic = 0;
    bit prev = 1'b1;
    total = 0; pmin = 1 << 30; pmax = 0; hibad = 0;
    while (edges <= warm + nper) begin
      @(negedge clk);
      if (clk_out && !prev) begin
        if (edges > warm) begin
          total += cyc;
          if (cyc < pmin) pmin = cyc;
          if (cyc > pmax) pmax = cyc;
          if (hic != cyc / 2) hibad++;
        end
        edges++;
        cyc = 0; hic = 0;
      end
      cyc++;
      if (clk_out) hic++;
      prev = clk_out;
    end
  endtask

  task automatic exact_case(input string req, input int ord, input int n,
                            input int f, input int expp, input int nper);
    longint tot; int mn; int mx; int hb;
    wr(0, ctlw(0, ord, 1'b1));
    wr(1, divw(n, f));
    measure(8, nper, tot, mn, mx, hb);
    check(mn == expp, req, "shortest period", mn, expp);
    check(mx == expp, req, "longest period", mx, expp);
    check(hb == 0, "R8", "periods with wrong high time", hb, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint tot; int mn; int mx; int hb; int highs; int rises; bit prev;

    repeat (5) @(negedge clk);
    // R1: reset and idle state
    check(clk_out == 1'b0, "R1", "clk_out during reset", clk_out, 0);
    rst_n = 1'b1;
    highs = 0;
    repeat (20) begin
      @(negedge clk);
      if (clk_out) highs++;
    end
    check(highs == 0, "R1", "high samples before enable", highs, 0);
    check(src_sel == 4'd0, "R1", "src_sel after reset", src_sel, 0);

    // R2/R3: divisor 0x13333 with the fraction disabled runs at 19
    wr(1, 32'h0001_3333);
    wr(0, 32'h0000_0011);
    check(src_sel == 4'd1, "R2", "src_sel after control write", src_sel, 1);
    measure(4, 16, tot, mn, mx, hb);
    check(mn == 19 && mx == 19, "R3", "period with fraction ignored", mx, 19);
    check(tot == 304, "R3", "16 period total", tot, 304);
    check(hb == 0, "R8", "high time at N=19", hb, 0);

    // R2/R4: control 0x291 turns the fraction on at order 1
    wr(0, 32'h0000_0291);
    wr(1, 32'h0001_3333);
    check(src_sel == 4'd1, "R2", "src_sel for 0x291", src_sel, 1);
    measure(8, 256, tot, mn, mx, hb);
    check(mn >= 19 && mx <= 20, "R4", "period span at N=19", mx, 20);
    check(tot == 4915 || tot == 4916, "R4", "256 period total at 19+819/4096", tot, 4915);

    // R3: order 0 with a different divisor
    exact_case("R3", 0, 5, 819, 5, 64);

    // R4: order 1 exact long-run ratio
    wr(0, ctlw(2, 1, 1'b1));
    wr(1, divw(4, 819));
    check(src_sel == 4'd2, "R2", "src_sel value 2", src_sel, 2);
    measure(8, 4096, tot, mn, mx, hb);
    check(mn >= 4 && mx <= 5, "R4", "period span order 1", mx, 5);
    check(tot == 17203, "R4", "4096 period total order 1", tot, 17203);
    check(hb == 0, "R8", "high time order 1", hb, 0);

    // R5: order 2
    wr(0, ctlw(0, 2, 1'b1));
    wr(1, divw(4, 1000));
    measure(8, 4096, tot, mn, mx, hb);
    check(mn >= 3 && mx <= 6, "R5", "period span order 2 max", mx, 6);
    check(mn >= 3, "R5", "period span order 2 min", mn, 3);
    check(tot >= 17383 && tot <= 17385, "R5", "4096 period total order 2", tot, 17384);
    check(hb == 0, "R8", "high time order 2", hb, 0);

    // R6: order 3
    wr(0, ctlw(0, 3, 1'b1));
    wr(1, divw(5, 2049));
    measure(8, 4096, tot, mn, mx, hb);
    check(mx <= 9, "R6", "period span order 3 max", mx, 9);
    check(mn >= 2, "R6", "period span order 3 min", mn, 2);
    check(tot >= 22526 && tot <= 22532, "R6", "4096 period total order 3", tot, 22529);
    check(hb == 0, "R8", "high time order 3", hb, 0);

    // R7: integer floors per order
    exact_case("R7", 0, 0, 0, 2, 16);
    exact_case("R7", 1, 1, 0, 2, 16);
    exact_case("R7", 2, 0, 0, 3, 16);
    exact_case("R7", 3, 2, 0, 5, 16);
    exact_case("R7", 3, 4, 0, 5, 16);
    exact_case("R7", 3, 6, 0, 6, 16);

    // R9: disable mid-period completes the period and holds low
    wr(0, ctlw(0, 0, 1'b1));
    wr(1, divw(6, 0));
    prev = 1'b1;
    do begin
      @(negedge clk);
      rises = (clk_out && !prev) ? 1 : 0;
      prev = clk_out;
    end while (rises == 0);
    cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = ctlw(0, 0, 1'b0);
    highs = 1; rises = 0; prev = 1'b1;
    repeat (40) begin
      @(negedge clk);
      cfg_wr = 1'b0;
      if (clk_out) highs++;
      if (clk_out && !prev) rises++;
      prev = clk_out;
    end
    check(highs == 3, "R9", "high samples in final period", highs, 3);
    check(rises == 0, "R9", "rising edges after disable", rises, 0);
    check(clk_out == 1'b0, "R9", "output level after disable", clk_out, 0);
    wr(0, ctlw(0, 0, 1'b1));
    measure(1, 4, tot, mn, mx, hb);
    check(mn == 6 && mx == 6, "R9", "period after re-enable", mn, 6);
    check(hb == 0, "R8", "high time after re-enable", hb, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule